// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether the next conditional branch will be taken, based only on what the most recent branches did. It does not use the branch address. A shift register keeps one bit per resolved branch, with 1 meaning taken. That register is used directly as the address into a table of saturating counters. The selected counter's top bit is the prediction, and it is offered every cycle as a combinational function of the stored state.

When the surrounding pipeline resolves a branch, it raises the update strobe and presents the actual direction. On that clock edge two things happen:

- The counter addressed by the current history moves one step toward the outcome, stopping at its limits.
- The outcome is shifted into the history.

The next prediction therefore already reflects both changes. When the strobe is low, nothing in the block changes.

The table depth and the counter width are parameters, with defaults of 32 entries and 2 bits. The history is as long as the table address, log2 of the depth.

Top module: `ghist_predictor`

## Requirements
- R1: After reset the history is all zeros and every counter holds the weakly-not-taken value (value 2^(W-1)-1, which is 1 for 2-bit counters), so the prediction is not taken (0).
- R2: The prediction output is 1 (taken) exactly when the most significant bit of the counter addressed by the current history is 1. It is valid in every cycle, including cycles without an update.
- R3: On an update with taken_i=1, the counter addressed by the history value from before the shift increments by one and saturates at all ones (3 for 2 bits).
- R4: On an update with taken_i=0, the counter addressed by the pre-shift history decrements by one and saturates at 0.
- R5: On an update, the history shifts left by one: the outcome enters bit 0 and the oldest bit is dropped. The new history and the new counter value are both visible in the prediction in the first cycle after the update edge.
- R6: While upd_i is low, the history and all counters hold, so the prediction is stable whatever taken_i does.
- R7: The history is exactly log2(ENTRIES) bits wide, so an outcome older than the last log2(ENTRIES) updates has no effect on the table address. ENTRIES must be a power of two of at least 4 and the counter width at least 1; this is checked at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| upd_i | input | 1 | A branch has resolved this cycle |
| taken_i | input | 1 | Resolved direction (1 = taken), used only when upd_i is high |
| pred_taken_o | output | 1 | Predicted direction for the next branch (1 = taken) |

## Verification
The assertions check every cycle that:
- the history shifts the outcome into bit 0 on an update and holds otherwise;
- each counter steps up or down by one, stops at its limits, and holds when it is not selected;
- the prediction does not move without an update.

Only the bench scenarios can show behaviour that spans many updates. This covers the reset value as seen at the output, the use of the pre-shift history as the write address, and the way patterns train the table. It also covers the fact that outcomes older than the history length stop mattering. A reference model of the table and history follows a long random update stream.

// File: rtl/ghist_pkg.sv
package ghist_pkg;
   typedef enum logic {
      GH_NOT_TAKEN = 1'b0,
      GH_TAKEN     = 1'b1
   } gh_dir_e;

   function automatic bit gh_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/ghist_history.sv
module ghist_history #(
   parameter int unsigned HIST_W = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              shift_i,
   input  logic              bit_i,
   output logic [HIST_W-1:0] hist_o
);
   logic [HIST_W-1:0] hist_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         hist_q <= '0;
      else if (shift_i)
         hist_q <= {hist_q[HIST_W-2:0], bit_i};
   end

   assign hist_o = hist_q;

   // R5: the outcome enters bit 0 and the older bits move up by one place
   p_hist_shift_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_i |=> hist_q == {$past(hist_q[HIST_W-2:0]), $past(bit_i)});

   // R6: no update, no history movement
   p_hist_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !shift_i |=> $stable(hist_q));
endmodule

// File: rtl/ghist_sat_ctr.sv
module ghist_sat_ctr #(
   parameter int unsigned CTR_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             up_i,
   output logic [CTR_W-1:0] val_o
);
   logic [CTR_W-1:0] val_q;

   generate
      if (CTR_W == 1) begin : g_single_bit
         // A one-bit counter simply remembers the last outcome.
         always_ff @(posedge clk_i) begin
            if (!rst_ni)
               val_q <= 1'b0;
            else if (en_i)
               val_q <= up_i;
         end

         p_bit_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            en_i |=> val_q == $past(up_i));
      end else begin : g_multi_bit
         localparam logic [CTR_W-1:0] TOP     = '1;
         localparam logic [CTR_W-1:0] WEAK_NT = {1'b0, {(CTR_W-1){1'b1}}};

         always_ff @(posedge clk_i) begin
            if (!rst_ni)
               val_q <= WEAK_NT;
            else if (en_i) begin
               if (up_i && val_q != TOP)
                  val_q <= val_q + 1'b1;
               else if (!up_i && val_q != '0)
                  val_q <= val_q - 1'b1;
            end
         end

         p_ctr_inc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (en_i && up_i && val_q != TOP) |=> val_q == $past(val_q) + 1'b1);
         p_ctr_sat_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (en_i && up_i && val_q == TOP) |=> val_q == TOP);
         p_ctr_dec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (en_i && !up_i && val_q != '0) |=> val_q == $past(val_q) - 1'b1);
         p_ctr_sat_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (en_i && !up_i && val_q == '0) |=> val_q == '0);
      end
   endgenerate

   assign val_o = val_q;

   // R6: an unselected counter keeps its value
   p_ctr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> $stable(val_q));
endmodule

// File: rtl/ghist_ctr_table.sv
module ghist_ctr_table #(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned CTR_W   = 2,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic             up_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic             msb_o
);
   logic [ENTRIES-1:0] sel;
   logic [ENTRIES-1:0] msbs;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      logic [CTR_W-1:0] val;

      assign sel[e] = wr_en_i && (idx_i == IDX_W'(e));

      ghist_sat_ctr #(.CTR_W(CTR_W)) u_ctr (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .en_i   (sel[e]),
         .up_i   (up_i),
         .val_o  (val)
      );

      assign msbs[e] = val[CTR_W-1];
   end

   assign msb_o = msbs[idx_i];
endmodule

// File: rtl/ghist_predictor.sv
module ghist_predictor #(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned CTR_W   = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic upd_i,
   input  logic taken_i,
   output logic pred_taken_o
);
   import ghist_pkg::*;

   localparam int unsigned HIST_W = $clog2(ENTRIES);

   // R7: elaboration-time parameter checks
   if (!gh_is_pow2(ENTRIES) || ENTRIES < 4) begin : g_bad_entries
      $error("ghist_predictor: ENTRIES must be a power of two of at least 4");
   end
   if (CTR_W < 1) begin : g_bad_width
      $error("ghist_predictor: CTR_W must be at least 1");
   end

   logic [HIST_W-1:0] hist;
   gh_dir_e           dir;

   assign dir = gh_dir_e'(taken_i);

   // The table writes at the pre-shift history; the history shifts on the same edge.
   ghist_ctr_table #(.ENTRIES(ENTRIES), .CTR_W(CTR_W)) u_table (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (upd_i),
      .up_i    (dir == GH_TAKEN),
      .idx_i   (hist),
      .msb_o   (pred_taken_o)
   );

   ghist_history #(.HIST_W(HIST_W)) u_hist (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .shift_i (upd_i),
      .bit_i   (taken_i),
      .hist_o  (hist)
   );

   // R6: without an update the prediction cannot change
   p_pred_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !upd_i |=> $stable(pred_taken_o));
endmodule

// File: tb/ghist_predictor_bench.sv
module ghist_predictor_bench;
   localparam int unsigned ENTRIES = 32;
   localparam int unsigned CTR_W   = 2;
   localparam int unsigned HIST_W  = $clog2(ENTRIES);
   localparam int          CMAX    = (1 << CTR_W) - 1;
   localparam int          HALF    = 1 << (CTR_W - 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic upd = 1'b0;
   logic taken = 1'b0;
   logic pred;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit finished = 0;

   int model_ctr [ENTRIES];
   int model_hist;

   logic  exp_q [$];
   string tag_q [$];

   always #2 clk = ~clk;

   ghist_predictor #(.ENTRIES(ENTRIES), .CTR_W(CTR_W)) u_ghist_predictor (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .upd_i        (upd),
      .taken_i      (taken),
      .pred_taken_o (pred)
   );

   task automatic check(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: prediction=%0b expected=%0b", tag, act, exp);
      end
   endtask

   // Driver: applies one cycle of stimulus and queues the prediction expected after the edge.
   task automatic step(input logic u, input logic t, input string tag);
      @(negedge clk);
      upd   = u;
      taken = t;
      if (u) begin
         if (t) begin
            if (model_ctr[model_hist] < CMAX) model_ctr[model_hist]++;
         end else begin
            if (model_ctr[model_hist] > 0) model_ctr[model_hist]--;
         end
         model_hist = ((model_hist << 1) | int'(t)) & (ENTRIES - 1);
      end
      exp_q.push_back(model_ctr[model_hist] >= HALF);
      tag_q.push_back(tag);
   endtask

   // Monitor: compares each queued item one time unit after the edge it refers to.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            automatic logic  e = exp_q.pop_front();
            automatic string g = tag_q.pop_front();
            check(pred, e, g);
         end
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000 && !finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, cycles=%0d expected<=100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      for (int i = 0; i < ENTRIES; i++) model_ctr[i] = HALF - 1;
      model_hist = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state is weakly not taken at history zero
      check(pred, 1'b0, "R1 reset prediction");

      // R6: taken_i toggles without update, prediction must hold
      for (int i = 0; i < 6; i++) step(1'b0, logic'(i[0]), "R6 no-update hold");

      // R5/R2: first taken update trains entry 0, history moves to 1
      step(1'b1, 1'b1, "R5 shift after taken");
      // R3: back to history 0 via 5 not-taken, then 1 taken update makes entry 0 saturate
      for (int i = 0; i < HIST_W; i++) step(1'b1, 1'b0, "R4 not-taken run");
      for (int i = 0; i < 4; i++) begin
         step(1'b1, 1'b1, "R3 train entry 0");
         for (int k = 0; k < HIST_W; k++) step(1'b1, 1'b0, "R3 return to entry 0");
      end

      // R3: long taken run saturates the all-ones entry
      for (int i = 0; i < 3 * HIST_W + 4; i++) step(1'b1, 1'b1, "R3 saturate high");
      // R6 again while trained state is visible
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R6 hold trained");

      // R4: long not-taken run saturates entry 0 at zero
      for (int i = 0; i < 3 * HIST_W + 4; i++) step(1'b1, 1'b0, "R4 saturate low");

      // R2/R5: alternating pattern trains two alternating entries
      for (int i = 0; i < 24; i++) step(1'b1, logic'(i[0]), "R2 alternating pattern");

      // R7: an old not-taken is forgotten after HIST_W taken updates
      for (int i = 0; i < HIST_W + 3; i++) step(1'b1, 1'b1, "R7 fill ones");
      step(1'b1, 1'b0, "R7 old outcome");
      for (int i = 0; i < HIST_W; i++) step(1'b1, 1'b1, "R7 old outcome forgotten");

      // R2/R3/R4/R5/R6: random stream against the model
      for (int i = 0; i < 3000; i++)
         step(logic'($urandom_range(0, 2) != 0), logic'($urandom_range(0, 1)),
              "R2 R3 R4 R5 R6 random");

      step(1'b0, 1'b0, "R6 final idle");
      repeat (3) @(negedge clk);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule